// File: doc/BRIEF.md
# Matrix Keypad Scanner and Encoder

This block turns a grid of plain make-contact switches into a binary key number. It has four column lines and four or five row lines, set by a parameter, so it serves a 16-key or a 20-key pad. It pulls one column low at a time and reads the row lines, which idle high through external pull-ups. When it finds a pressed key, the scan stops on that column. The block then waits for the key's row to stay low for a programmable number of scan ticks. After that wait it stores the key number and raises a data-available flag.

The flag drops on the first scan tick that sees the accepted key open. This happens even if other keys are still down. Scanning then moves on from the next column, so a key still held is found again and must pass a fresh debounce wait before it is accepted. This gives two-key roll-over. The stored number remains on the output bus until another key is accepted. The bus floats whenever the output-enable input is low, so several encoders can share it. A one-cycle scan-tick input sets the scan rate, and every state change happens on a tick.

Top module: `keypad_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the stored code to 0, drives `data_avail` low and drives column 0 low (`cols_n` = 4'b1110).
- R2: Exactly one bit of `cols_n` is low at all times, and bit c low means column c is active. With no key detected, each cycle with `scan_tick` high moves the active column to the next index, wrapping from 3 to 0. With `scan_tick` low, the column does not change.
- R3: The key number is row index × 4 + column index, both counted from zero. It is presented on the 5-bit `key_code`, with bit 4 being the top bit. Bit 4 is 1 only for numbers 16 to 19, which exist only when five rows are present.
- R4: A key seen low on a tick freezes the scan on its column. The key is accepted only after `deb_len` further ticks on which its row is still low. On acceptance the code is stored and `data_avail` goes high after that same edge.
- R5: If the row reads high on any tick during the debounce wait, the wait is dropped and the block returns to scanning the same column. The count starts again from zero on the next detection.
- R6: With `deb_len` = 0, a key is accepted on the same tick that first sees it.
- R7: Once a key is accepted, `data_avail` drops on the first tick that reads its row high on the frozen column, even if other keys are pressed. Scanning then resumes at the next column.
- R8: A second key held when the first is released is accepted only after its own full debounce wait, and `data_avail` then rises again with the new code.
- R9: The stored code changes only when a key is accepted. After a release it keeps the last accepted number.
- R10: With `oe` high, `key_code` drives the stored code. With `oe` low, `key_code` is high-impedance.
- R11: If several rows are low on the active column, the lowest-numbered row is the one encoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_tick | input | 1 | One-cycle scan-rate enable |
| deb_len | input | CNT_W (8) | Debounce length in ticks; 0 disables debounce |
| oe | input | 1 | Output enable for `key_code` |
| rows_n | input | NUM_ROWS (5) | Row lines, low when a key on the active column is closed |
| cols_n | output | 4 | Column drives, one low at a time |
| key_code | output | 5 | Stored key number, high-impedance while `oe` is low |
| data_avail | output | 1 | High while an accepted key remains pressed |

## Verification
The bench models the switch grid behaviourally, so the row lines respond to whichever column the block is driving. It covers these cases:
- a single press with a long hold, which separates correct debounce counting and release from an early or late flag;
- a press broken by a short bounce, which shows whether the count restarts;
- two overlapping keys on different columns, which exercises roll-over and shows whether the fresh debounce wait is enforced;
- two keys on one column, which shows whether row priority is lowest-first;
- a top-row key with debounce disabled and every-cycle ticks, which exercises bit 4 and immediate acceptance.

Tick-free stretches and `oe` toggling separate a scan that advances on ticks from one that free-runs, and a floating bus from a driven one.

// File: rtl/keypad_pkg.sv
// Shared constants and state type for the keypad encoder.
// Assumes a fixed four-column grid; row count is set per instance.
package keypad_pkg;
    localparam int KEY_COLS = 4;
    localparam int COL_W    = 2;
    localparam int CODE_W   = 5;

    typedef enum logic [1:0] {
        ST_SCAN   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_HELD   = 2'd2
    } kp_state_e;
endpackage

// File: rtl/kp_col_driver.sv
// Column driver: keeps the active column index and drives one column low.
// Assumes the sequencer asserts 'step' only on scan ticks.
module kp_col_driver #(
    parameter int NUM_COLS = 4,
    parameter int COL_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    output logic [COL_W-1:0]    col_idx,
    output logic [NUM_COLS-1:0] cols_n
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    logic [COL_W-1:0] col_q;

    // Advance the column with wrap-around when stepped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            col_q <= '0;
        else if (step)
            col_q <= (col_q == LAST_COL) ? '0 : col_q + COL_W'(1);
    end

    assign col_idx = col_q;

    // One driver per column: low only when selected.
    generate
        for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
            assign cols_n[c] = (col_q != COL_W'(c));
        end
    endgenerate
endmodule

// File: rtl/kp_row_pick.sv
// Row priority picker: finds the lowest-numbered row reading low.
// Purely combinational; assumes rows are already synchronous to clk.
module kp_row_pick #(
    parameter int NUM_ROWS = 5,
    parameter int ROW_W    = 3
) (
    input  logic [NUM_ROWS-1:0] rows_n,
    output logic                hit,
    output logic [ROW_W-1:0]    row_idx
);
    // Scan from the top so the lowest low row is assigned last.
    always_comb begin
        hit     = 1'b0;
        row_idx = '0;
        for (int r = NUM_ROWS - 1; r >= 0; r--) begin
            if (!rows_n[r]) begin
                hit     = 1'b1;
                row_idx = ROW_W'(r);
            end
        end
    end
endmodule

// File: rtl/kp_debounce.sv
// Debounce counter: counts stable ticks and flags the final one.
// A length of zero means acceptance on detection ('bypass').
module kp_debounce #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             count,
    input  logic [CNT_W-1:0] len,
    output logic             bypass,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // Hold the number of stable ticks seen so far.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (count)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign bypass = (len == '0);
    assign last   = bypass || (cnt_q == len - CNT_W'(1));
endmodule

// File: rtl/keypad_encoder.sv
// Keypad encoder top: scan sequencer, code register, flag and bus driver.
// Assumes rows_n is synchronous to clk and settled one cycle after a column
// change; all state moves only on scan_tick.
module keypad_encoder
    import keypad_pkg::*;
#(
    parameter int NUM_ROWS = 5,
    parameter int CNT_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_tick,
    input  logic [CNT_W-1:0]      deb_len,
    input  logic                  oe,
    input  logic [NUM_ROWS-1:0]   rows_n,
    output logic [KEY_COLS-1:0]   cols_n,
    output logic [CODE_W-1:0]     key_code,
    output logic                  data_avail
);
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;

    kp_state_e          state_q, state_d;
    logic [ROW_W-1:0]   row_q, row_idx, src_row;
    logic [COL_W-1:0]   col_idx;
    logic [CODE_W-1:0]  code_q;
    logic               da_q;
    logic               hit, held_low, col_step;
    logic               deb_clear, deb_count, deb_bypass, deb_last;
    logic               accept, release_key;

    kp_col_driver #(.NUM_COLS(KEY_COLS), .COL_W(COL_W)) u_cols (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (col_step),
        .col_idx (col_idx),
        .cols_n  (cols_n)
    );

    kp_row_pick #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_rows (
        .rows_n  (rows_n),
        .hit     (hit),
        .row_idx (row_idx)
    );

    kp_debounce #(.CNT_W(CNT_W)) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (deb_clear),
        .count  (deb_count),
        .len    (deb_len),
        .bypass (deb_bypass),
        .last   (deb_last)
    );

    assign held_low = !rows_n[row_q];

    // Sequencer: decide detection, settling, acceptance and release per tick.
    always_comb begin
        state_d     = state_q;
        col_step    = 1'b0;
        deb_clear   = 1'b0;
        deb_count   = 1'b0;
        accept      = 1'b0;
        release_key = 1'b0;
        if (scan_tick) begin
            unique case (state_q)
                ST_SCAN: begin
                    if (hit) begin
                        deb_clear = 1'b1;
                        if (deb_bypass) begin
                            accept  = 1'b1;
                            state_d = ST_HELD;
                        end else begin
                            state_d = ST_SETTLE;
                        end
                    end else begin
                        col_step = 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (!held_low) begin
                        deb_clear = 1'b1;
                        state_d   = ST_SCAN;
                    end else if (deb_last) begin
                        accept  = 1'b1;
                        state_d = ST_HELD;
                    end else begin
                        deb_count = 1'b1;
                    end
                end
                ST_HELD: begin
                    if (!held_low) begin
                        release_key = 1'b1;
                        col_step    = 1'b1;
                        state_d     = ST_SCAN;
                    end
                end
                default: state_d = ST_SCAN;
            endcase
        end
    end

    assign src_row = (state_q == ST_SCAN) ? row_idx : row_q;

    // State and captured row: row is latched on first detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            if (scan_tick && state_q == ST_SCAN && hit)
                row_q <= row_idx;
        end
    end

    // Last-key register and data-available flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            da_q   <= 1'b0;
        end else begin
            if (accept) begin
                code_q <= CODE_W'({src_row, col_idx});
                da_q   <= 1'b1;
            end else if (release_key) begin
                da_q   <= 1'b0;
            end
        end
    end

    assign data_avail = da_q;
    assign key_code   = oe ? code_q : 'z;
endmodule

// File: rtl/keypad_encoder_checker.sv
// Property checker for keypad_encoder, attached by bind below.
// Observes ports plus the internal code register.
module keypad_encoder_checker #(
    parameter int NUM_COLS = 4,
    parameter int CODE_W   = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scan_tick,
    input logic                oe,
    input logic [NUM_COLS-1:0] cols_n,
    input logic                data_avail,
    input logic [CODE_W-1:0]   key_code,
    input logic [CODE_W-1:0]   code_q
);
    p_one_col_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cols_n) == 1);

    p_col_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(cols_n));

    p_rise_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_avail) |-> $past(scan_tick));

    p_fall_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_avail) |-> $past(scan_tick));

    p_code_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(data_avail) |-> $stable(code_q));

    p_top_bit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        code_q[CODE_W-1] |-> (code_q[CODE_W-2:CODE_W-3] == 2'b00));

    p_bus_driven_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (key_code == code_q));
endmodule

bind keypad_encoder keypad_encoder_checker #(
    .NUM_COLS(keypad_pkg::KEY_COLS),
    .CODE_W  (keypad_pkg::CODE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_tick  (scan_tick),
    .oe         (oe),
    .cols_n     (cols_n),
    .data_avail (data_avail),
    .key_code   (key_code),
    .code_q     (code_q)
);

// File: tb/keypad_encoder_bench.sv
// Bench: behavioural switch grid, cycle-by-cycle reference model, and
// directed scenarios. Inputs change at the falling edge; outputs are
// compared 1 ns after it.
module keypad_encoder_bench;
    localparam int ROWS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_tick = 1'b0;
    logic [7:0]  deb_len = 8'd3;
    logic        oe = 1'b1;
    logic [ROWS-1:0] rows_n;
    wire  [3:0]  cols_n;
    wire  [4:0]  key_code;
    wire         data_avail;

    bit   [19:0] pressed = '0;
    int          tick_mode = 0;   // 0 every other cycle, 1 every cycle, 2 none
    int          cyc = 0;
    int          vectors = 0;
    int          fails = 0;
    bit          done = 1'b0;

    // reference model state
    int m_st = 0, m_col = 0, m_row = 0, m_cnt = 0, m_code = 0;
    bit m_da = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    keypad_encoder #(.NUM_ROWS(ROWS), .CNT_W(8)) u_keypad_encoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_tick  (scan_tick),
        .deb_len    (deb_len),
        .oe         (oe),
        .rows_n     (rows_n),
        .cols_n     (cols_n),
        .key_code   (key_code),
        .data_avail (data_avail)
    );

    // Switch grid: a row reads low when a closed key sits on a low column.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            rows_n[r] = 1'b1;
            for (int c = 0; c < 4; c++)
                if (pressed[r*4+c] && !cols_n[c]) rows_n[r] = 1'b0;
        end
    end

    // Tick generator.
    always @(negedge clk) begin
        cyc++;
        case (tick_mode)
            0: scan_tick = cyc[0];
            1: scan_tick = 1'b1;
            default: scan_tick = 1'b0;
        endcase
    end

    function automatic int low_row(int col);
        for (int r = 0; r < ROWS; r++)
            if (pressed[r*4+col]) return r;
        return -1;
    endfunction

    // Reference model: behaviour written from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_col = 0; m_row = 0; m_cnt = 0; m_code = 0; m_da = 1'b0;
        end else if (scan_tick) begin
            case (m_st)
                0: begin
                    int r;
                    r = low_row(m_col);
                    if (r >= 0) begin
                        m_row = r; m_cnt = 0;
                        if (deb_len == 0) begin
                            m_code = r*4 + m_col; m_da = 1'b1; m_st = 2;
                        end else m_st = 1;
                    end else m_col = (m_col + 1) % 4;
                end
                1: begin
                    if (!pressed[m_row*4+m_col]) begin
                        m_st = 0; m_cnt = 0;
                    end else if (m_cnt == int'(deb_len) - 1) begin
                        m_code = m_row*4 + m_col; m_da = 1'b1; m_st = 2;
                    end else m_cnt++;
                end
                default: begin
                    if (!pressed[m_row*4+m_col]) begin
                        m_da = 1'b0; m_st = 0; m_col = (m_col + 1) % 4;
                    end
                end
            endcase
        end
    end

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        #1;
        if (!done) begin
            check("R2 column", int'(cols_n), int'(~(4'b1 << m_col)) & 15);
            check("R4 R5 R6 R7 R8 data_avail", int'(data_avail), int'(m_da));
            if (oe) begin
                check("R3 R9 R11 key_code", int'(key_code), m_code);
            end else begin
                vectors++;
                if (!((key_code === 5'bzzzzz) || (key_code === 5'b00000))) begin
                    fails++;
                    $display("FAIL R10: actual %b expected zzzzz", key_code);
                end
            end
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_da(bit level, string req);
        int k;
        k = 0;
        while (k < 400) begin
            @(negedge clk); #1;
            if (data_avail == level) break;
            k++;
        end
        if (k == 400) begin
            fails++; vectors++;
            $display("FAIL %s: data_avail actual %0d expected %0d (timeout)", req, !level, level);
        end
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] snap;
        cycles(4);
        #1;
        check("R1 cols", int'(cols_n), 14);
        check("R1 flag", int'(data_avail), 0);
        check("R1 code", int'(key_code), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cycles(20);

        // R2: no ticks, column must hold.
        tick_mode = 2;
        @(negedge clk); #1; snap = cols_n;
        cycles(6); #1;
        check("R2 hold", int'(cols_n), int'(snap));
        @(negedge clk);
        tick_mode = 0;

        // R3 R4: single key, row 2 column 1.
        pressed[9] = 1'b1;
        wait_da(1'b1, "R4");
        check("R3 code", int'(key_code), 9);
        cycles(10);
        pressed[9] = 1'b0;
        wait_da(1'b0, "R7");
        check("R9 kept", int'(key_code), 9);

        // R5: bounce during the wait.
        pressed[6] = 1'b1;
        cycles(4);
        pressed[6] = 1'b0;
        cycles(2);
        pressed[6] = 1'b1;
        cycles(2); #1;
        check("R5 no early flag", int'(data_avail), 0);
        wait_da(1'b1, "R5");
        check("R5 code", int'(key_code), 6);

        // R8: roll-over from key 6 to key 13.
        pressed[13] = 1'b1;
        cycles(8);
        pressed[6] = 1'b0;
        wait_da(1'b0, "R7");
        #1;
        check("R7 low with other key held", int'(data_avail), 0);
        wait_da(1'b1, "R8");
        check("R8 code", int'(key_code), 13);
        pressed[13] = 1'b0;
        wait_da(1'b0, "R7");

        // R11: two rows on column 0.
        pressed[4] = 1'b1; pressed[12] = 1'b1;
        wait_da(1'b1, "R11");
        check("R11 lowest row", int'(key_code), 4);
        pressed[4] = 1'b0; pressed[12] = 1'b0;
        wait_da(1'b0, "R7");

        // R6 R3: debounce off, every-cycle ticks, top row key 18.
        deb_len = 8'd0;
        tick_mode = 1;
        pressed[18] = 1'b1;
        wait_da(1'b1, "R6");
        check("R6 code", int'(key_code), 18);
        check("R3 top bit", int'(key_code[4]), 1);

        // R10: bus floats then drives again.
        oe = 1'b0;
        cycles(5);
        oe = 1'b1;
        cycles(1); #1;
        check("R10 redriven", int'(key_code), 18);
        pressed[18] = 1'b0;
        wait_da(1'b0, "R7");
        check("R9 kept after release", int'(key_code), 18);
        cycles(10);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule